// File: doc/BRIEF.md
# Interleaved Multithreaded Hart Sequencer

This block is the fetch front end of a barrel processor. It holds one program counter for each hardware thread (hart) and hands out fetch slots to the harts in a fixed rotation, one hart per cycle. Each issued slot carries the hart's current PC as the fetch address, together with the hart number. The hart count is at least three, so two neighbouring pipeline slots never belong to the same hart. Because of that, a taken branch or jump reported by execute only rewrites the owning hart's PC. No other slot in flight is affected, and there is no flush. The same spacing keeps a hart's register-file write apart from its next read, so the block has no stall logic for data dependencies.

The block also holds one software-interrupt pending flag per hart. Any hart may raise the flag of any hart, and a hart clears its own flag. When a clear and a set meet on the same flag in the same cycle, the clear wins. Execute-side redirects and interrupt requests carry a hart number. A number at or above the hart count is ignored.

Top module: `hart_sequencer`

## Requirements
- R1: While reset is asserted, every hart PC equals BOOT_ADDR, all pending flags are 0, `fetch_hart_o` is 0 and `fetch_vld_o` is 0. From the first clock edge after reset is released, `fetch_vld_o` is 1.
- R2: A slot is issued on a clock edge where `fetch_vld_o` and `fetch_rdy_i` are both 1. After each issued slot, `fetch_hart_o` moves to the next hart in ID order and wraps from NUM_HARTS-1 back to 0.
- R3: `fetch_addr_o` is the current PC of the hart shown on `fetch_hart_o`. Issuing a slot with no redirect for that hart adds 4 to that hart's PC.
- R4: On an edge where `fetch_rdy_i` is 0, no slot is issued, and `fetch_hart_o`, `fetch_addr_o` and all PCs hold their values.
- R5: A redirect (`redir_vld_i`=1) for hart h < NUM_HARTS writes `redir_pc_i` into h's PC at the next edge. The other harts' PCs and the rotation are not affected.
- R6: A redirect for the hart whose slot issues at the same edge overrides the increment of 4.
- R7: A set request (`swi_set_vld_i`) for hart h < NUM_HARTS makes bit h of `swi_pend_o` 1 after the next edge. The bit stays 1 until it is cleared.
- R8: A clear request (`swi_clr_vld_i`) for hart h makes bit h 0 after the next edge. This also holds when a set for the same hart arrives in the same cycle.
- R9: A set and a clear that target different harts in the same cycle both take effect.
- R10: A redirect, set or clear whose hart number is NUM_HARTS or more has no effect on any PC or pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_rdy_i | input | 1 | Fetch stage accepts the offered slot |
| redir_vld_i | input | 1 | Redirect request from execute |
| redir_hart_i | input | HID_W | Hart that owns the redirect |
| redir_pc_i | input | PC_W | New PC for that hart |
| swi_set_vld_i | input | 1 | Raise a software interrupt |
| swi_set_hart_i | input | HID_W | Hart whose flag is raised |
| swi_clr_vld_i | input | 1 | Clear a software interrupt |
| swi_clr_hart_i | input | HID_W | Hart whose own flag is cleared |
| fetch_vld_o | output | 1 | A fetch slot is offered |
| fetch_hart_o | output | HID_W | Hart owning the offered slot |
| fetch_addr_o | output | PC_W | Fetch address of the offered slot |
| swi_pend_o | output | NUM_HARTS | Pending software-interrupt flag per hart |

## Verification
Every result of the block becomes visible exactly one clock edge after the input that causes it. This covers a PC step, a redirect, the advance of the rotation, and a set or clear of a pending flag. The bench drives all inputs on the falling edge. It updates its own model of the PCs, the rotation pointer and the flags at that same time, as the value the next rising edge will produce. It then compares every output on the following falling edge, half a period after that rising edge. Directed cases are placed where slot order decides the outcome: a redirect into the issuing slot, a set and a clear on one flag, and out-of-range hart numbers.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
    localparam int MIN_HARTS = 3;
    localparam int PC_STEP   = 4;
endpackage

// File: rtl/hseq_rr_sel.sv
module hseq_rr_sel #(
    parameter int NUM_HARTS = 3,
    parameter int HID_W     = $clog2(NUM_HARTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rdy_i,
    output logic             vld_o,
    output logic             issue_o,
    output logic [HID_W-1:0] hart_o
);
    localparam logic [HID_W-1:0] LAST = HID_W'(NUM_HARTS - 1);

    typedef struct packed {
        logic             vld;
        logic [HID_W-1:0] ptr;
    } sel_t;

    sel_t sel_d, sel_q;

    assign vld_o   = sel_q.vld;
    assign hart_o  = sel_q.ptr;
    assign issue_o = sel_q.vld & rdy_i;

    always_comb begin
        sel_d     = sel_q;
        sel_d.vld = 1'b1;
        if (issue_o) begin
            sel_d.ptr = (sel_q.ptr == LAST) ? '0 : sel_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    // R2: each issued slot hands the next one to the following hart
    p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |=> hart_o == (($past(hart_o) == LAST) ? '0 : $past(hart_o) + 1'b1));

    // R4: no issue means no movement
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_i |=> $stable(hart_o));

    // R1: valid from the first edge after reset release
    p_valid_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> vld_o);
endmodule

// File: rtl/hseq_pc_file.sv
module hseq_pc_file
    import hseq_pkg::*;
#(
    parameter int                NUM_HARTS = 3,
    parameter int                PC_W      = 32,
    parameter int                HID_W     = $clog2(NUM_HARTS),
    parameter logic [PC_W-1:0]   BOOT_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [HID_W-1:0] issue_hart_i,
    input  logic             redir_vld_i,
    input  logic [HID_W-1:0] redir_hart_i,
    input  logic [PC_W-1:0]  redir_pc_i,
    output logic [PC_W-1:0]  fetch_addr_o
);
    localparam logic [HID_W:0]  HART_LIM = (HID_W+1)'(NUM_HARTS);
    localparam logic [PC_W-1:0] STEP     = PC_W'(PC_STEP);

    typedef struct packed {
        logic [NUM_HARTS-1:0][PC_W-1:0] pc;
    } pcs_t;

    pcs_t pcs_d, pcs_q;
    logic redir_ok;

    assign redir_ok     = redir_vld_i && ({1'b0, redir_hart_i} < HART_LIM);
    assign fetch_addr_o = pcs_q.pc[issue_hart_i];

    always_comb begin
        pcs_d = pcs_q;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (issue_i && issue_hart_i == HID_W'(h)) begin
                pcs_d.pc[h] = pcs_q.pc[h] + STEP;
            end
            if (redir_ok && redir_hart_i == HID_W'(h)) begin
                pcs_d.pc[h] = redir_pc_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcs_q <= {NUM_HARTS{BOOT_ADDR}};
        end else begin
            pcs_q <= pcs_d;
        end
    end

    // R5/R6: a valid redirect always lands at the next edge
    p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_ok |=> pcs_q.pc[$past(redir_hart_i)] == $past(redir_pc_i));

    // R3: an issued slot without redirect advances its hart by one word
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !(redir_ok && redir_hart_i == issue_hart_i))
        |=> pcs_q.pc[$past(issue_hart_i)] == $past(fetch_addr_o) + STEP);

    // R4: nothing issued and nothing redirected leaves all PCs alone
    p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i && !redir_vld_i) |=> $stable(pcs_q));
endmodule

// File: rtl/hseq_swi.sv
module hseq_swi #(
    parameter int NUM_HARTS = 3,
    parameter int HID_W     = $clog2(NUM_HARTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_vld_i,
    input  logic [HID_W-1:0]     set_hart_i,
    input  logic                 clr_vld_i,
    input  logic [HID_W-1:0]     clr_hart_i,
    output logic [NUM_HARTS-1:0] pend_o
);
    localparam logic [HID_W:0] HART_LIM = (HID_W+1)'(NUM_HARTS);

    typedef struct packed {
        logic [NUM_HARTS-1:0] pend;
    } swi_t;

    swi_t swi_d, swi_q;
    logic set_ok, clr_ok;

    assign set_ok = set_vld_i && ({1'b0, set_hart_i} < HART_LIM);
    assign clr_ok = clr_vld_i && ({1'b0, clr_hart_i} < HART_LIM);
    assign pend_o = swi_q.pend;

    always_comb begin
        swi_d = swi_q;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (set_ok && set_hart_i == HID_W'(h)) begin
                swi_d.pend[h] = 1'b1;
            end
            if (clr_ok && clr_hart_i == HID_W'(h)) begin
                swi_d.pend[h] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swi_q <= '0;
        end else begin
            swi_q <= swi_d;
        end
    end

    // R8: clear always wins on its own flag
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ok |=> !pend_o[$past(clr_hart_i)]);

    // R7: an uncontested set raises the flag
    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ok && !(clr_ok && clr_hart_i == set_hart_i)) |=> pend_o[$past(set_hart_i)]);

    // R10: no valid request, no flag change
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ok && !clr_ok) |=> $stable(pend_o));
endmodule

// File: rtl/hart_sequencer.sv
module hart_sequencer #(
    parameter int              NUM_HARTS = 3,
    parameter int              PC_W      = 32,
    parameter int              HID_W     = $clog2(NUM_HARTS),
    parameter logic [PC_W-1:0] BOOT_ADDR = PC_W'(32'h0000_1000)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_rdy_i,
    input  logic                 redir_vld_i,
    input  logic [HID_W-1:0]     redir_hart_i,
    input  logic [PC_W-1:0]      redir_pc_i,
    input  logic                 swi_set_vld_i,
    input  logic [HID_W-1:0]     swi_set_hart_i,
    input  logic                 swi_clr_vld_i,
    input  logic [HID_W-1:0]     swi_clr_hart_i,
    output logic                 fetch_vld_o,
    output logic [HID_W-1:0]     fetch_hart_o,
    output logic [PC_W-1:0]      fetch_addr_o,
    output logic [NUM_HARTS-1:0] swi_pend_o
);
    logic issue;

    hseq_rr_sel #(
        .NUM_HARTS (NUM_HARTS),
        .HID_W     (HID_W)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy_i   (fetch_rdy_i),
        .vld_o   (fetch_vld_o),
        .issue_o (issue),
        .hart_o  (fetch_hart_o)
    );

    hseq_pc_file #(
        .NUM_HARTS (NUM_HARTS),
        .PC_W      (PC_W),
        .HID_W     (HID_W),
        .BOOT_ADDR (BOOT_ADDR)
    ) u_pcs (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .issue_hart_i (fetch_hart_o),
        .redir_vld_i  (redir_vld_i),
        .redir_hart_i (redir_hart_i),
        .redir_pc_i   (redir_pc_i),
        .fetch_addr_o (fetch_addr_o)
    );

    hseq_swi #(
        .NUM_HARTS (NUM_HARTS),
        .HID_W     (HID_W)
    ) u_swi (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vld_i  (swi_set_vld_i),
        .set_hart_i (swi_set_hart_i),
        .clr_vld_i  (swi_clr_vld_i),
        .clr_hart_i (swi_clr_hart_i),
        .pend_o     (swi_pend_o)
    );

    // R4: a held slot keeps its address
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_rdy_i && !redir_vld_i) |=> $stable(fetch_addr_o));
endmodule

// File: tb/hart_sequencer_tb_top.sv
module hart_sequencer_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          NH    = 3;
    localparam int          PW    = 32;
    localparam int          HW    = 2;
    localparam logic [31:0] BOOT  = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rdy = 1'b0, rv = 1'b0, sv = 1'b0, cv = 1'b0;
    logic [HW-1:0] rh = '0, sh = '0, ch = '0;
    logic [PW-1:0] rpc = '0;
    logic          vld;
    logic [HW-1:0] hart;
    logic [PW-1:0] addr;
    logic [NH-1:0] pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [PW-1:0] e_pc [NH];
    int            e_ptr;
    logic          e_vld;
    logic [NH-1:0] e_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    hart_sequencer #(.NUM_HARTS(NH), .PC_W(PW), .BOOT_ADDR(BOOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_rdy_i(rdy),
        .redir_vld_i(rv), .redir_hart_i(rh), .redir_pc_i(rpc),
        .swi_set_vld_i(sv), .swi_set_hart_i(sh),
        .swi_clr_vld_i(cv), .swi_clr_hart_i(ch),
        .fetch_vld_o(vld), .fetch_hart_o(hart), .fetch_addr_o(addr), .swi_pend_o(pend)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(string req);
        chk(req, "valid", 32'(vld), 32'(e_vld));
        chk(req, "hart", 32'(hart), 32'(e_ptr));
        chk(req, "addr", addr, e_pc[e_ptr]);
        chk(req, "pend", 32'(pend), 32'(e_pend));
    endtask

    // drive one cycle of stimulus, advance the model, check after the edge
    task automatic step(string req, logic i_rdy, logic i_rv, logic [HW-1:0] i_rh,
                        logic [PW-1:0] i_rpc, logic i_sv, logic [HW-1:0] i_sh,
                        logic i_cv, logic [HW-1:0] i_ch);
        bit iss;
        rdy = i_rdy; rv = i_rv; rh = i_rh; rpc = i_rpc;
        sv = i_sv; sh = i_sh; cv = i_cv; ch = i_ch;
        iss = e_vld && i_rdy;
        if (iss) e_pc[e_ptr] = e_pc[e_ptr] + 32'd4;
        if (i_rv && int'(i_rh) < NH) e_pc[int'(i_rh)] = i_rpc;
        if (iss) e_ptr = (e_ptr + 1) % NH;
        if (i_sv && int'(i_sh) < NH) e_pend[int'(i_sh)] = 1'b1;
        if (i_cv && int'(i_ch) < NH) e_pend[int'(i_ch)] = 1'b0;
        e_vld = 1'b1;
        @(negedge clk);
        compare(req);
    endtask

    task automatic idle(string req, logic i_rdy);
        step(req, i_rdy, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NH; i++) e_pc[i] = BOOT;
        e_ptr = 0; e_vld = 1'b0; e_pend = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        idle("R1", 1'b1);

        // R2/R3: free-running rotation, two full rounds
        for (int i = 0; i < 2*NH; i++) idle("R2", 1'b1);

        // R4: stall holds slot and address
        for (int i = 0; i < 4; i++) idle("R4", 1'b0);
        idle("R3", 1'b1);

        // R5: redirect a hart that is not issuing, while stalled
        step("R5", 1'b0, 1'b1, HW'((e_ptr + 1) % NH), 32'h0000_8000, 1'b0, '0, 1'b0, '0);
        idle("R5", 1'b1);
        idle("R5", 1'b1);

        // R6: redirect the hart whose slot issues now
        step("R6", 1'b1, 1'b1, HW'(e_ptr), 32'h0000_A000, 1'b0, '0, 1'b0, '0);
        for (int i = 0; i < NH; i++) idle("R6", 1'b1);

        // R7: set flags, they persist
        step("R7", 1'b1, 1'b0, '0, '0, 1'b1, 2'd1, 1'b0, '0);
        idle("R7", 1'b1);
        idle("R7", 1'b0);

        // R8: clear beats set on the same hart
        step("R8", 1'b1, 1'b0, '0, '0, 1'b1, 2'd2, 1'b0, '0);
        step("R8", 1'b1, 1'b0, '0, '0, 1'b1, 2'd2, 1'b1, 2'd2);
        step("R8", 1'b1, 1'b0, '0, '0, 1'b1, 2'd0, 1'b1, 2'd0);

        // R9: set and clear on different harts together
        step("R9", 1'b1, 1'b0, '0, '0, 1'b1, 2'd0, 1'b1, 2'd1);

        // R10: out-of-range hart numbers do nothing
        step("R10", 1'b1, 1'b1, 2'd3, 32'hDEAD_BEE0, 1'b1, 2'd3, 1'b0, '0);
        step("R10", 1'b0, 1'b1, 2'd3, 32'h1234_5670, 1'b0, '0, 1'b1, 2'd3);
        for (int i = 0; i < NH; i++) idle("R10", 1'b1);

        // R2/R3/R5/R7: constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            step("R2/R3/R5/R7",
                 ($urandom % 4) != 0,
                 ($urandom % 4) == 0, HW'($urandom), $urandom & 32'hFFFF_FFFC,
                 ($urandom % 5) == 0, HW'($urandom),
                 ($urandom % 5) == 0, HW'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule